// File: doc/BRIEF.md
# Thread-Context Matcher for Interrupt Presentation

This block takes one notification request and finds which hardware thread has the addressed virtual target dispatched, and on which privilege ring. A request names a target by block number and index, carries a format bit, an ignore bit and a logical-server identifier, and comes with the validity flag of the target's descriptor. From block and index the block forms a content-addressable (CAM) key. It then walks the context words of every thread, one thread per clock cycle, and compares the key against the hypervisor-pool, OS and user rings of each thread.

The result is one of five outcomes, reported together with a one-cycle done pulse: a single match (thread number and ring), a duplicate match, not dispatched, invalid target, or unsupported mode. Requests with an invalid descriptor or an unsupported mode finish in one cycle and do not scan. Exception delivery, backlog, escalation and logical-server arbitration belong to other blocks.

The controller has three named states. `S_IDLE` waits for `start_i`. On start it goes to `S_DONE` if the descriptor is invalid or the mode is unsupported, and to `S_SCAN` otherwise. `S_SCAN` examines one thread per cycle. It leaves for `S_DONE` when a second match is found or the last thread has been examined. `S_DONE` lasts one cycle and always returns to `S_IDLE`.

Top module: `thread_ctx_matcher`

## Requirements
- R1: The key is the block number placed above bit 19 and ORed with the 19-bit index (key = blk << 19 | idx, 23 bits). A ring compares all 23 bits, so a context that differs from the key only in a block bit does not match.
- R2: If `desc_vld_i` is low at start, the block scans no thread. It raises `done_o` one cycle after start with status invalid-target (status bit 3).
- R3: With format 0 and the ignore bit set, the block returns unsupported (status bit 4) one cycle after start and reports no match.
- R4: With format 0, the pool ring of a thread is tried first. It matches when the pool valid bit is set and the pool key equals the request key, giving ring code 2. It takes precedence when the OS ring of the same thread also matches.
- R5: With format 0, if the pool ring of a thread does not match, the OS ring is tried. It matches when the OS valid bit is set and the OS key equals the request key, giving ring code 1.
- R6: With format 1, a thread matches (ring code 0) only when four conditions all hold: OS valid is set, the OS key equals the request key, user valid is set, and the user logical-server field equals the requested ID. The pool ring is not considered, and the ignore bit has no effect.
- R7: A single matching thread gives status match (bit 0), its thread number and ring code, with `done_o` high NUM_THR+1 cycles after start.
- R8: When a second thread matches, the block ends the scan at that thread with status duplicate (bit 1). Thread and ring keep the first match, so `done_o` comes j+2 cycles after start for a second match at thread j.
- R9: When no thread matches after all threads are examined, the status is not-dispatched (bit 2), NUM_THR+1 cycles after start.
- R10: While `done_o` is high exactly one status bit is set, and `done_o` lasts one cycle. `busy_o` is high from the cycle after start until done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken in idle |
| fmt_i | input | 1 | Format: 0 pool/OS rings, 1 user ring |
| ign_i | input | 1 | Ignore bit (logical-server mode with format 0) |
| blk_i | input | BLK_W | Target block number |
| idx_i | input | IDX_W | Target index |
| lsid_i | input | LSID_W | Requested logical-server ID |
| desc_vld_i | input | 1 | Valid flag of the target descriptor |
| pool_vld_i | input | NUM_THR | Pool ring valid bit per thread |
| pool_cam_i | input | NUM_THR*CAM_W | Pool ring key per thread |
| os_vld_i | input | NUM_THR | OS ring valid bit per thread |
| os_cam_i | input | NUM_THR*CAM_W | OS ring key per thread |
| usr_vld_i | input | NUM_THR | User ring valid bit per thread |
| usr_lsid_i | input | NUM_THR*LSID_W | User ring logical-server field per thread |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 5 | One-hot: 0 match, 1 duplicate, 2 not dispatched, 3 invalid, 4 unsupported |
| thread_o | output | TID_W | Thread of the first match |
| ring_o | output | 2 | Ring of the first match: 0 user, 1 OS, 2 pool |

## Verification
The embedded properties check on every cycle that the early exits take exactly one cycle, and that the pool ring wins under format 0. They also check that a format-1 hit is always a user ring backed by both valid bits, that a second hit ends the scan as a duplicate, and that a completion has one status bit and a one-cycle pulse. Only the bench scenarios can show the end-to-end results: which thread and ring are reported for a given placement of contexts, the latency for matches at the first and last thread, that a wrong logical-server ID or a flipped block bit gives not-dispatched, and that a start during a scan leaves the result unchanged.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2
    } ring_e;

    localparam int ST_W      = 5;
    localparam int ST_MATCH  = 0;
    localparam int ST_DUP    = 1;
    localparam int ST_NODISP = 2;
    localparam int ST_INVAL  = 3;
    localparam int ST_UNSUP  = 4;
endpackage

// File: rtl/ptm_thread_sel.sv
module ptm_thread_sel #(
    parameter int NUM_THR = 8,
    parameter int CAM_W   = 23,
    parameter int LSID_W  = 8,
    parameter int TID_W   = 3
) (
    input  logic [TID_W-1:0]          sel_i,
    input  logic [NUM_THR-1:0]        pool_vld_i,
    input  logic [NUM_THR*CAM_W-1:0]  pool_cam_i,
    input  logic [NUM_THR-1:0]        os_vld_i,
    input  logic [NUM_THR*CAM_W-1:0]  os_cam_i,
    input  logic [NUM_THR-1:0]        usr_vld_i,
    input  logic [NUM_THR*LSID_W-1:0] usr_lsid_i,
    output logic                      pool_vld_o,
    output logic [CAM_W-1:0]          pool_cam_o,
    output logic                      os_vld_o,
    output logic [CAM_W-1:0]          os_cam_o,
    output logic                      usr_vld_o,
    output logic [LSID_W-1:0]         usr_lsid_o
);
    logic [CAM_W-1:0]  pool_cam_a [NUM_THR];
    logic [CAM_W-1:0]  os_cam_a   [NUM_THR];
    logic [LSID_W-1:0] usr_lsid_a [NUM_THR];

    for (genvar t = 0; t < NUM_THR; t++) begin : g_unpack
        assign pool_cam_a[t] = pool_cam_i[t*CAM_W +: CAM_W];
        assign os_cam_a[t]   = os_cam_i[t*CAM_W +: CAM_W];
        assign usr_lsid_a[t] = usr_lsid_i[t*LSID_W +: LSID_W];
    end

    assign pool_vld_o = pool_vld_i[sel_i];
    assign pool_cam_o = pool_cam_a[sel_i];
    assign os_vld_o   = os_vld_i[sel_i];
    assign os_cam_o   = os_cam_a[sel_i];
    assign usr_vld_o  = usr_vld_i[sel_i];
    assign usr_lsid_o = usr_lsid_a[sel_i];
endmodule

// File: rtl/ptm_ring_match.sv
module ptm_ring_match
    import ptm_pkg::*;
#(
    parameter int CAM_W  = 23,
    parameter int LSID_W = 8
) (
    input  logic              fmt_i,
    input  logic [CAM_W-1:0]  key_i,
    input  logic [LSID_W-1:0] lsid_i,
    input  logic              pool_vld_i,
    input  logic [CAM_W-1:0]  pool_cam_i,
    input  logic              os_vld_i,
    input  logic [CAM_W-1:0]  os_cam_i,
    input  logic              usr_vld_i,
    input  logic [LSID_W-1:0] usr_lsid_i,
    output logic              hit_o,
    output ring_e             ring_o
);
    logic pool_eq, os_eq, usr_eq;

    assign pool_eq = pool_vld_i && (pool_cam_i == key_i);
    assign os_eq   = os_vld_i && (os_cam_i == key_i);
    assign usr_eq  = usr_vld_i && (usr_lsid_i == lsid_i);

    always_comb begin
        hit_o  = 1'b0;
        ring_o = RING_USER;
        if (!fmt_i) begin
            // pool ring outranks OS ring (R4, R5)
            if (pool_eq) begin
                hit_o  = 1'b1;
                ring_o = RING_POOL;
            end else if (os_eq) begin
                hit_o  = 1'b1;
                ring_o = RING_OS;
            end
        end else if (os_eq && usr_eq) begin
            hit_o  = 1'b1;
            ring_o = RING_USER;
        end
    end
endmodule

// File: rtl/thread_ctx_matcher.sv
module thread_ctx_matcher
    import ptm_pkg::*;
#(
    parameter int NUM_THR = 8,
    parameter int BLK_W   = 4,
    parameter int IDX_W   = 19,
    parameter int LSID_W  = 8,
    localparam int CAM_W  = BLK_W + IDX_W,
    localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      fmt_i,
    input  logic                      ign_i,
    input  logic [BLK_W-1:0]          blk_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [LSID_W-1:0]         lsid_i,
    input  logic                      desc_vld_i,
    input  logic [NUM_THR-1:0]        pool_vld_i,
    input  logic [NUM_THR*CAM_W-1:0]  pool_cam_i,
    input  logic [NUM_THR-1:0]        os_vld_i,
    input  logic [NUM_THR*CAM_W-1:0]  os_cam_i,
    input  logic [NUM_THR-1:0]        usr_vld_i,
    input  logic [NUM_THR*LSID_W-1:0] usr_lsid_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [ST_W-1:0]           status_o,
    output logic [TID_W-1:0]          thread_o,
    output logic [1:0]                ring_o
);
    localparam logic [TID_W-1:0] LAST_THR = TID_W'(NUM_THR - 1);

    state_e             state, nxt;
    logic               req_fmt;
    logic [CAM_W-1:0]   req_key;
    logic [LSID_W-1:0]  req_lsid;
    logic [TID_W-1:0]   cnt;
    logic               found;
    logic [ST_W-1:0]    status_q;
    logic [TID_W-1:0]   thr_q;
    ring_e              ring_q;

    logic               sel_pool_vld, sel_os_vld, sel_usr_vld;
    logic [CAM_W-1:0]   sel_pool_cam, sel_os_cam;
    logic [LSID_W-1:0]  sel_usr_lsid;
    logic               hit;
    ring_e              hit_ring;
    logic               is_last;
    logic               early_exit;

    ptm_thread_sel #(
        .NUM_THR(NUM_THR), .CAM_W(CAM_W), .LSID_W(LSID_W), .TID_W(TID_W)
    ) u_sel (
        .sel_i(cnt),
        .pool_vld_i(pool_vld_i), .pool_cam_i(pool_cam_i),
        .os_vld_i(os_vld_i),     .os_cam_i(os_cam_i),
        .usr_vld_i(usr_vld_i),   .usr_lsid_i(usr_lsid_i),
        .pool_vld_o(sel_pool_vld), .pool_cam_o(sel_pool_cam),
        .os_vld_o(sel_os_vld),     .os_cam_o(sel_os_cam),
        .usr_vld_o(sel_usr_vld),   .usr_lsid_o(sel_usr_lsid)
    );

    ptm_ring_match #(.CAM_W(CAM_W), .LSID_W(LSID_W)) u_match (
        .fmt_i(req_fmt), .key_i(req_key), .lsid_i(req_lsid),
        .pool_vld_i(sel_pool_vld), .pool_cam_i(sel_pool_cam),
        .os_vld_i(sel_os_vld),     .os_cam_i(sel_os_cam),
        .usr_vld_i(sel_usr_vld),   .usr_lsid_i(sel_usr_lsid),
        .hit_o(hit), .ring_o(hit_ring)
    );

    assign is_last    = (cnt == LAST_THR);
    assign early_exit = !desc_vld_i || (!fmt_i && ign_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start_i) nxt = early_exit ? S_DONE : S_SCAN;
            S_SCAN: if ((hit && found) || is_last) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // request capture, scan bookkeeping and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_fmt  <= 1'b0;
            req_key  <= '0;
            req_lsid <= '0;
            cnt      <= '0;
            found    <= 1'b0;
            status_q <= '0;
            thr_q    <= '0;
            ring_q   <= RING_USER;
        end else begin
            unique case (state)
                S_IDLE: if (start_i) begin
                    req_fmt  <= fmt_i;
                    req_key  <= {blk_i, idx_i};
                    req_lsid <= lsid_i;
                    cnt      <= '0;
                    found    <= 1'b0;
                    thr_q    <= '0;
                    ring_q   <= RING_USER;
                    status_q <= '0;
                    if (!desc_vld_i)
                        status_q[ST_INVAL] <= 1'b1;
                    else if (!fmt_i && ign_i)
                        status_q[ST_UNSUP] <= 1'b1;
                end
                S_SCAN: begin
                    cnt <= cnt + 1'b1;
                    if (hit && found) begin
                        status_q[ST_DUP] <= 1'b1;
                    end else if (hit) begin
                        found  <= 1'b1;
                        thr_q  <= cnt;
                        ring_q <= hit_ring;
                        if (is_last) status_q[ST_MATCH] <= 1'b1;
                    end else if (is_last) begin
                        if (found) status_q[ST_MATCH]  <= 1'b1;
                        else       status_q[ST_NODISP] <= 1'b1;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy_o   = (state != S_IDLE);
    assign done_o   = (state == S_DONE);
    assign status_o = status_q;
    assign thread_o = thr_q;
    assign ring_o   = ring_q;

    // ---------------- assertions ----------------
    p_inval_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_i && !desc_vld_i) |=>
            (done_o && status_o == 5'b01000));

    p_unsup_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_i && desc_vld_i && !fmt_i && ign_i) |=>
            (done_o && status_o == 5'b10000));

    p_pool_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && !req_fmt && sel_pool_vld && sel_pool_cam == req_key) |->
            (hit && hit_ring == RING_POOL));

    p_user_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && req_fmt && hit) |->
            (hit_ring == RING_USER && sel_os_vld && sel_usr_vld));

    p_dup_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && hit && found) |=> (done_o && status_o[ST_DUP]));

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(status_o) == 1));

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_i) |=> busy_o);
endmodule

// File: tb/test_thread_ctx_matcher.sv
module test_thread_ctx_matcher;
    localparam int N      = 8;
    localparam int CAM_W  = 23;
    localparam int LSID_W = 8;

    typedef struct packed {
        int          rq;
        logic        fmt;
        logic        ign;
        logic        dvld;
        logic [3:0]  blk;
        logic [18:0] idx;
        logic [7:0]  lsid;
        int          ta;
        logic [2:0]  ka;
        int          tb;
        logic [2:0]  kb;
        logic [4:0]  est;
        int          eth;
        logic [1:0]  erg;
        int          elat;
    } vec_t;

    // kinds: 0 none, 1 pool key, 2 OS key, 3 OS key + user lsid,
    // 4 OS key + wrong lsid, 5 pool and OS key, 6 pool key with pool valid low,
    // 7 pool key with block bit 19 flipped
    localparam vec_t VECS [16] = '{
        '{4, 0,0,1, 4'h3, 19'h00A5C, 8'h11, 3, 3'd1, -1, 3'd0, 5'b00001, 3, 2'd2, 9},  // R4
        '{5, 0,0,1, 4'h1, 19'h12345, 8'h22, 5, 3'd2, -1, 3'd0, 5'b00001, 5, 2'd1, 9},  // R5
        '{4, 0,0,1, 4'h2, 19'h00001, 8'h00, 2, 3'd5, -1, 3'd0, 5'b00001, 2, 2'd2, 9},  // R4 precedence
        '{4, 0,0,1, 4'h6, 19'h70000, 8'h00, 1, 3'd6, -1, 3'd0, 5'b00100, 0, 2'd0, 9},  // R4 valid low
        '{6, 1,0,1, 4'h5, 19'h0BEEF, 8'h3C, 7, 3'd3, -1, 3'd0, 5'b00001, 7, 2'd0, 9},  // R6
        '{6, 1,0,1, 4'h5, 19'h0BEEF, 8'h3C, 4, 3'd4, -1, 3'd0, 5'b00100, 0, 2'd0, 9},  // R6 lsid
        '{6, 1,0,1, 4'h7, 19'h00100, 8'h01, 0, 3'd1, -1, 3'd0, 5'b00100, 0, 2'd0, 9},  // R6 pool ignored
        '{8, 0,0,1, 4'h9, 19'h00042, 8'h00, 2, 3'd1,  6, 3'd2, 5'b00010, 2, 2'd2, 8},  // R8
        '{9, 0,0,1, 4'hA, 19'h1FFFF, 8'h00,-1, 3'd0, -1, 3'd0, 5'b00100, 0, 2'd0, 9},  // R9
        '{2, 0,0,0, 4'h3, 19'h00A5C, 8'h00, 3, 3'd1, -1, 3'd0, 5'b01000, 0, 2'd0, 1},  // R2
        '{3, 0,1,1, 4'h3, 19'h00A5C, 8'h00, 3, 3'd1, -1, 3'd0, 5'b10000, 0, 2'd0, 1},  // R3
        '{1, 0,0,1, 4'hF, 19'h7FFFF, 8'h00, 0, 3'd7, -1, 3'd0, 5'b00100, 0, 2'd0, 9},  // R1 block bit
        '{1, 0,0,1, 4'hF, 19'h7FFFF, 8'h00, 0, 3'd1, -1, 3'd0, 5'b00001, 0, 2'd2, 9},  // R1 full key
        '{6, 1,1,1, 4'h8, 19'h00777, 8'h99, 6, 3'd3, -1, 3'd0, 5'b00001, 6, 2'd0, 9},  // R6 ignore bit
        '{8, 1,0,1, 4'h4, 19'h00004, 8'h05, 0, 3'd3,  7, 3'd3, 5'b00010, 0, 2'd0, 9},  // R8 last thread
        '{7, 0,0,1, 4'hC, 19'h01234, 8'h00, 7, 3'd2, -1, 3'd0, 5'b00001, 7, 2'd1, 9}   // R7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, fmt = 1'b0, ign = 1'b0, dvld = 1'b0;
    logic [3:0]  blk = '0;
    logic [18:0] idx = '0;
    logic [7:0]  lsid = '0;
    logic [N-1:0] pv = '0, ov = '0, uv = '0;
    logic [N*CAM_W-1:0]  pc = '0, oc = '0;
    logic [N*LSID_W-1:0] ul = '0;
    logic busy, done;
    logic [4:0] status;
    logic [2:0] thread;
    logic [1:0] ring;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    thread_ctx_matcher i_thread_ctx_matcher (
        .clk(clk), .rst_n(rst_n), .start_i(start), .fmt_i(fmt), .ign_i(ign),
        .blk_i(blk), .idx_i(idx), .lsid_i(lsid), .desc_vld_i(dvld),
        .pool_vld_i(pv), .pool_cam_i(pc), .os_vld_i(ov), .os_cam_i(oc),
        .usr_vld_i(uv), .usr_lsid_i(ul),
        .busy_o(busy), .done_o(done), .status_o(status),
        .thread_o(thread), .ring_o(ring)
    );

    task automatic chk(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic logic [CAM_W-1:0] key_of(input logic [3:0] b, input logic [18:0] i);
        return (CAM_W'(b) << 19) | CAM_W'(i);
    endfunction

    task automatic place(input int t, input logic [2:0] k,
                         input logic [CAM_W-1:0] key, input logic [7:0] ls);
        if (t < 0) return;
        case (k)
            3'd1: pc[t*CAM_W +: CAM_W] = key;
            3'd2: oc[t*CAM_W +: CAM_W] = key;
            3'd3: begin oc[t*CAM_W +: CAM_W] = key; ul[t*LSID_W +: LSID_W] = ls; end
            3'd4: begin oc[t*CAM_W +: CAM_W] = key; ul[t*LSID_W +: LSID_W] = ls ^ 8'h01; end
            3'd5: begin pc[t*CAM_W +: CAM_W] = key; oc[t*CAM_W +: CAM_W] = key; end
            3'd6: begin pc[t*CAM_W +: CAM_W] = key; pv[t] = 1'b0; end
            3'd7: pc[t*CAM_W +: CAM_W] = key ^ (CAM_W'(1) << 19);
            default: ;
        endcase
    endtask

    task automatic setup(input vec_t v);
        logic [CAM_W-1:0] key;
        key  = key_of(v.blk, v.idx);
        fmt  = v.fmt; ign = v.ign; dvld = v.dvld;
        blk  = v.blk; idx = v.idx; lsid = v.lsid;
        pv = '1; ov = '1; uv = '1;
        for (int t = 0; t < N; t++) begin
            pc[t*CAM_W +: CAM_W]   = key ^ CAM_W'(t + 1);
            oc[t*CAM_W +: CAM_W]   = key ^ (CAM_W'(t + 1) << 8);
            ul[t*LSID_W +: LSID_W] = v.lsid ^ 8'hA5;
        end
        place(v.ta, v.ka, key, v.lsid);
        place(v.tb, v.kb, key, v.lsid);
    endtask

    // pulse start, return cycles until done
    task automatic launch(output int lat);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input string tag, input vec_t v, input int lat);
        chk({tag, " status"}, int'(status), int'(v.est));
        chk({tag, " latency"}, lat, v.elat);
        if (v.est[0] || v.est[1]) begin
            chk({tag, " thread"}, int'(thread), v.eth);
            chk({tag, " ring"}, int'(ring), int'(v.erg));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin : main
        int lat;
        int extra;
        repeat (3) @(negedge clk);
        // reset state (R10)
        chk("R10 reset busy", int'(busy), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset status", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            string tag;
            setup(VECS[i]);
            launch(lat);
            tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            check_result(tag, VECS[i], lat);
            @(negedge clk);
            chk({tag, " done one cycle R10"}, int'(done), 0);
        end

        // R10: start during scan is ignored, busy held, single done pulse
        setup(VECS[0]);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 busy mid-scan", int'(busy), 1);
        dvld = 1'b0; fmt = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check_result("R10 restart ignored", VECS[0], lat);
        extra = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10 no second done", extra, 0);
        chk("R10 idle after done", int'(busy), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule